// File: doc/BRIEF.md
# E-Clock Phase-Aligned Acknowledge Wait Timer

This block times the wait a processor core spends on a slow synchronous peripheral cycle: an interrupt acknowledge that is answered by the "valid peripheral address" handshake and then runs in step with the slow E clock. The length of that wait is not fixed. It depends on where the request lands inside the E clock period, which repeats every 10 processor clocks.

On a start strobe the block samples a free-running master clock counter and a clock divider. The master count is divided by the divider, with the remainder thrown away, to give the processor clock count. The phase within the E period is that count modulo 10. The wait is 9 + phase processor clocks of acknowledge plus 4 processor clocks of idle bus. This total is scaled back to master clocks by multiplying it by the divider. A down-counter loaded at the start edge raises a busy flag for the wait. It then emits a single-cycle done pulse, exactly that many master clocks after the start cycle.

Top module: `eclk_ack_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `done` are both 0.
- R2: The processor clock count is floor(`mclk_count` / divider). The remainder of that division is discarded and does not affect the wait.
- R3: The E phase is the processor clock count modulo 10. A phase of 0 gives the shortest wait (13 processor clocks) and a phase of 9 gives the longest (22).
- R4: If `start` is high in a cycle with `busy` low, the wait W = (13 + phase) × divider master clocks. `done` is high in the cycle W cycles after that start cycle.
- R5: `busy` is high in every cycle from the one after the accepted start up to the cycle before `done`. It is low in the `done` cycle.
- R6: `done` is high for exactly one cycle. With no new start, `busy` and `done` are both 0 in the following cycle.
- R7: A `start` while `busy` is high is ignored. The running wait ends at its original time.
- R8: A divider value of 0 acts as a divider of 1.
- R9: A `start` in the `done` cycle is accepted, and a new wait begins at once.
- R10: `mclk_count` and `clk_div` are only sampled at the accepted start. Changing them during the wait does not change its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a wait; taken only when not busy |
| mclk_count | input | CNT_W | Free-running master clock count, sampled on start |
| clk_div | input | DIV_W | Master-to-processor clock divider, 0 treated as 1 |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle pulse at the end of the wait |

## Verification
`busy` rises one cycle after an accepted start. `done` is due exactly W cycles after the start cycle, where W is worked out in the bench from the sampled count and divider. Each check drives inputs on the falling edge and counts cycles from the start cycle. At every falling edge up to W it samples `busy` and `done`, and it records the first cycle where either one is wrong. The cycle after `done` is sampled separately, to confirm the pulse width and the return to idle. Extra starts and input changes are injected at known cycle numbers inside the window.

// File: rtl/eat_pkg.sv
package eat_pkg;

    // Length of one E clock period in processor clocks
    localparam int unsigned E_PERIOD  = 10;
    // Minimum acknowledge length in processor clocks
    localparam int unsigned ACK_BASE  = 9;
    // Idle bus tail after the acknowledge, in processor clocks
    localparam int unsigned IDLE_TAIL = 4;
    // Bits needed to hold a phase value
    localparam int unsigned PHASE_W   = $clog2(E_PERIOD);
    // Bits needed for the processor-clock wait factor
    localparam int unsigned FACT_W    = $clog2(ACK_BASE + IDLE_TAIL + E_PERIOD);

endpackage

// File: rtl/eat_udiv.sv
// Unrolled restoring division that produces only the quotient.
module eat_udiv #(
    parameter int unsigned NUM_W = 32,
    parameter int unsigned DEN_W = 8
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo
);
    // partial remainder entering each stage, always below den
    logic [DEN_W-1:0] rem_s [NUM_W];

    assign rem_s[0] = '0;

    for (genvar gi = 0; gi < NUM_W; gi++) begin : g_stage
        logic [DEN_W:0] trial;
        logic           fits;
        assign trial = {rem_s[gi], num[NUM_W-1-gi]};
        assign fits  = (trial >= {1'b0, den});
        assign quo[NUM_W-1-gi] = fits;
        if (gi < NUM_W - 1) begin : g_next
            logic [DEN_W:0] diff;
            assign diff          = trial - {1'b0, den};
            assign rem_s[gi + 1] = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        end
    end

endmodule

// File: rtl/eat_urem.sv
// Unrolled restoring reduction that produces only the remainder.
module eat_urem #(
    parameter int unsigned NUM_W = 32,
    parameter int unsigned DEN_W = 4
) (
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [DEN_W-1:0] rem
);
    logic [DEN_W-1:0] rem_s [NUM_W+1];

    assign rem_s[0] = '0;

    for (genvar gi = 0; gi < NUM_W; gi++) begin : g_stage
        logic [DEN_W:0] trial;
        logic [DEN_W:0] diff;
        assign trial = {rem_s[gi], num[NUM_W-1-gi]};
        assign diff  = trial - {1'b0, den};
        assign rem_s[gi + 1] = (trial >= {1'b0, den}) ? diff[DEN_W-1:0]
                                                      : trial[DEN_W-1:0];
    end

    assign rem = rem_s[NUM_W];

endmodule

// File: rtl/eat_phase.sv
// Position inside the E period derived from the master count.
module eat_phase
    import eat_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned DIV_W = 8
) (
    input  logic [CNT_W-1:0]   mclk_count,
    input  logic [DIV_W-1:0]   div_eff,
    output logic [PHASE_W-1:0] phase
);
    localparam logic [PHASE_W-1:0] PERIOD_C = PHASE_W'(E_PERIOD);

    logic [CNT_W-1:0] cpu_count;

    eat_udiv #(
        .NUM_W (CNT_W),
        .DEN_W (DIV_W)
    ) u_cpu_div (
        .num (mclk_count),
        .den (div_eff),
        .quo (cpu_count)
    );

    eat_urem #(
        .NUM_W (CNT_W),
        .DEN_W (PHASE_W)
    ) u_e_mod (
        .num (cpu_count),
        .den (PERIOD_C),
        .rem (phase)
    );

endmodule

// File: rtl/eat_scale.sv
// Shift-and-add product of the divider and the wait factor.
module eat_scale #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned FACT_W = 5,
    localparam int unsigned OUT_W = DIV_W + FACT_W
) (
    input  logic [DIV_W-1:0]  div_eff,
    input  logic [FACT_W-1:0] factor,
    output logic [OUT_W-1:0]  product
);
    logic [OUT_W-1:0] acc [FACT_W+1];

    assign acc[0] = '0;

    for (genvar gk = 0; gk < FACT_W; gk++) begin : g_term
        logic [OUT_W-1:0] term;
        assign term        = factor[gk] ? (OUT_W'(div_eff) << gk) : '0;
        assign acc[gk + 1] = acc[gk] + term;
    end

    assign product = acc[FACT_W];

endmodule

// File: rtl/eclk_ack_timer.sv
module eclk_ack_timer
    import eat_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] mclk_count,
    input  logic [DIV_W-1:0] clk_div,
    output logic             busy,
    output logic             done
);
    localparam int unsigned WAIT_W = DIV_W + FACT_W;
    localparam logic [FACT_W-1:0] FIXED_PART = FACT_W'(ACK_BASE + IDLE_TAIL);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [WAIT_W-1:0] cnt;
    } tmr_state_t;

    logic [DIV_W-1:0]   div_eff;
    logic [PHASE_W-1:0] phase;
    logic [FACT_W-1:0]  factor;
    logic [WAIT_W-1:0]  wait_len;
    tmr_state_t         st_d, st_q;

    // zero divider behaves as one
    assign div_eff = (clk_div == '0) ? DIV_W'(1) : clk_div;

    eat_phase #(
        .CNT_W (CNT_W),
        .DIV_W (DIV_W)
    ) u_phase (
        .mclk_count (mclk_count),
        .div_eff    (div_eff),
        .phase      (phase)
    );

    assign factor = FIXED_PART + FACT_W'(phase);

    eat_scale #(
        .DIV_W  (DIV_W),
        .FACT_W (FACT_W)
    ) u_scale (
        .div_eff (div_eff),
        .factor  (factor),
        .product (wait_len)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == WAIT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - WAIT_W'(1);
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = wait_len - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

endmodule

// File: rtl/eat_checker.sv
module eat_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done
);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_ends_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_start_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_follows_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));

endmodule

bind eclk_ack_timer eat_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
);

// File: tb/eclk_ack_timer_tb.sv
`timescale 1ns/1ps
module eclk_ack_timer_tb;
    localparam int CW = 32;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] mclk = '0;
    logic [DW-1:0] cdiv = 8'd1;
    logic          busy, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    eclk_ack_timer #(.CNT_W(CW), .DIV_W(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mclk_count (mclk),
        .clk_div    (cdiv),
        .busy       (busy),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wait_of(input int cnt, input int dv);
        int d = (dv == 0) ? 1 : dv;
        return (13 + ((cnt / d) % 10)) * d;
    endfunction

    // called at a falling edge: present a start for this cycle
    task automatic launch(input int cnt, input int dv);
        mclk  = CW'(cnt);
        cdiv  = DW'(dv);
        start = 1'b1;
    endtask

    // walks the wait window; returns at the falling edge of cycle exp_w
    task automatic wait_check(input int exp_w, input string req, input int poke_at,
                              input int poke_cnt, input bit scramble);
        int first_bad = -1;
        int done_at   = -1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= exp_w; n++) begin
            if (n < exp_w && (busy !== 1'b1 || done !== 1'b0) && first_bad < 0)
                first_bad = n;
            if (done === 1'b1 && done_at < 0) done_at = n;
            if (n == exp_w) break;
            start = (n == poke_at);
            if (n == poke_at) mclk = CW'(poke_cnt);
            else mclk = mclk + 1;
            if (scramble) cdiv = ~cdiv;
            @(negedge clk);
        end
        start = 1'b0;
        check(first_bad < 0, "R5", "first cycle with wrong busy/done", first_bad, -1);
        check(done_at == exp_w && busy === 1'b0, req, "done cycle", done_at, exp_w);
    endtask

    task automatic idle_after(input string req);
        start = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, req, "busy,done after pulse",
              {busy, done}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy,done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy,done after reset", {busy, done}, 0);
    endtask

    task automatic t_basic();
        launch(164, 7);   // cpu 23, phase 3, 16*7
        check(wait_of(164, 7) == 112, "R4", "model wait", wait_of(164, 7), 112);
        wait_check(112, "R4", -1, 0, 1'b0);
        idle_after("R6");
    endtask

    task automatic t_phase_edges();
        launch(40, 1);    // phase 0
        wait_check(13, "R3", -1, 0, 1'b0);
        idle_after("R6");
        launch(49, 1);    // phase 9
        wait_check(22, "R3", -1, 0, 1'b0);
        idle_after("R6");
    endtask

    task automatic t_remainder();
        launch(79, 4);    // 79/4 = 19 rem 3, phase 9, 22*4
        wait_check(88, "R2", -1, 0, 1'b0);
        idle_after("R6");
    endtask

    task automatic t_div_zero();
        launch(25, 0);    // as divider 1: phase 5, 18
        wait_check(18, "R8", -1, 0, 1'b0);
        idle_after("R6");
    endtask

    task automatic t_start_while_busy();
        launch(0, 2);     // phase 0, 13*2; second start would give phase 4
        wait_check(26, "R7", 5, 9, 1'b0);
        idle_after("R7");
    endtask

    task automatic t_chain();
        launch(40, 1);
        wait_check(13, "R9", -1, 0, 1'b0);
        launch(33, 3);    // in the done cycle: cpu 11, phase 1, 14*3
        wait_check(42, "R9", -1, 0, 1'b0);
        idle_after("R6");
    endtask

    task automatic t_inputs_held();
        launch(164, 7);
        wait_check(112, "R10", -1, 0, 1'b1);
        idle_after("R10");
    endtask

    task automatic t_large();
        launch(315535, 255);   // cpu 1237, phase 7, 20*255
        wait_check(5100, "R4", -1, 0, 1'b0);
        idle_after("R6");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_phase_edges();
        t_remainder();
        t_div_zero();
        t_start_while_busy();
        t_chain();
        t_inputs_held();
        t_large();
        summary();
        $finish;
    end

endmodule